// File: doc/BRIEF.md
# Programmable Scan Timing Generator

This block generates the slow internal timebase and the four shared scan lines used by a keyboard and display controller. A prescaler divides the system clock by a programmable ratio N. The ratio is normally chosen so that the internal rate is about 100 kHz. Each prescaler tick feeds a dwell counter. After a fixed number of ticks, the scan position moves on by one.

The scan lines have two formats, selected by a single mode input:

- **Binary mode:** the four lines carry the scan count as an active-high binary value from 0 to 15. An external 4-to-16 decoder turns this into sixteen digit strobes. Only the lower eight positions are valid keyboard rows.
- **One-cold mode:** the count is limited to four positions. The lines show an active-low pattern with exactly one line low, so a 4-digit display or a 4-row key matrix can be wired directly.

The display and keyboard sections receive three further signals from this block:

- the current scan index;
- a flag that marks whether the current row belongs to the keyboard;
- a one-cycle pulse just before each scan advance, used to blank the digits while they switch.

Top module: `scan_timebase`

## Requirements
- R1: While reset is held and in the first cycle after it, scan_idx is 0, scan_out is 4'b0000 (binary mode), and tick and digit_switch are 0.
- R2: With div_n between 2 and 31, tick is high for one clock in every div_n clocks.
- R3: A div_n value of 0 or 1 behaves exactly like a value of 2.
- R4: scan_idx advances once for every DWELL_TICKS ticks, so one scan position lasts div_n × DWELL_TICKS clocks.
- R5: In binary mode (decoded = 0), scan_out equals scan_idx. The index counts 0, 1, … 15 and then wraps to 0.
- R6: In one-cold mode (decoded = 1), scan_idx counts 0..3 and wraps. scan_out has bit scan_idx low and all other bits high: 1110, 1101, 1011, 0111.
- R7: digit_switch is high for exactly the one clock before each scan_idx advance, and only in that clock. It is high only while tick is high.
- R8: A clock edge at which decoded differs from the active mode clears the scan count, dwell count and prescaler phase to 0 and adopts the new mode.
- R9: kbd_active is high when scan_idx is 0..7 in binary mode and low when it is 8..15. In one-cold mode it is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_n | input | 5 | Prescaler ratio; 0 and 1 act as 2 |
| decoded | input | 1 | 0 selects binary scan, 1 selects one-cold scan |
| scan_out | output | 4 | Scan lines |
| scan_idx | output | 4 | Current scan position |
| kbd_active | output | 1 | Current position is a keyboard row |
| tick | output | 1 | One-clock prescaler pulse |
| digit_switch | output | 1 | One-clock pulse before each scan advance |

## Verification
The scan sequence is run several times, each with a different ratio and mode:

- **Binary mode, ratio 3, full wrap:** the run goes once past 15, so the wrap back to 0 shows the full count width. The row flag is checked on both the keyboard half and the display-only half.
- **One-cold mode:** this shows whether the pattern is active low with a single line low, and whether the count wraps after four positions.
- **Ratio 1 and ratio 0:** these confirm that both values behave exactly like ratio 2.
- **Ratio 31:** this checks the widest prescaler setting.

Every run is started by switching the mode. This checks that a mode change clears the scan count from a nonzero position. The clocks between advances and the ticks within each position are counted for every step. These counts separate a prescaler error from a dwell counter error.

// File: rtl/scan_timebase.sv
module scan_timebase #(
  parameter int DIV_W       = 5,
  parameter int DWELL_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             decoded,
  output logic [3:0]       scan_out,
  output logic [3:0]       scan_idx,
  output logic             kbd_active,
  output logic             tick,
  output logic             digit_switch
);
  localparam int DW_W = $clog2(DWELL_TICKS + 1);
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL_TICKS - 1);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] pre_cnt;
  logic [DW_W-1:0]  dw_cnt;
  logic [3:0]       scan_cnt;
  logic             mode_q;
  logic             mode_chg;
  logic [DIV_W-1:0] eff_n;
  logic [DIV_W-1:0] pre_last;
  logic             dw_end;
  logic [3:0]       scan_next;

  assign eff_n    = (div_n < MIN_DIV) ? MIN_DIV : div_n;
  assign pre_last = eff_n - DIV_W'(1);
  assign mode_chg = decoded != mode_q;
  assign tick     = (pre_cnt >= pre_last) && !mode_chg;
  assign dw_end   = dw_cnt == DW_LAST;
  assign digit_switch = tick && dw_end;

  assign scan_next = mode_q ? {2'b00, scan_cnt[1:0] + 2'd1} : scan_cnt + 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      dw_cnt   <= '0;
      scan_cnt <= '0;
      mode_q   <= 1'b0;
    end else if (mode_chg) begin
      pre_cnt  <= '0;
      dw_cnt   <= '0;
      scan_cnt <= '0;
      mode_q   <= decoded;
    end else if (tick) begin
      pre_cnt <= '0;
      if (dw_end) begin
        dw_cnt   <= '0;
        scan_cnt <= scan_next;
      end else begin
        dw_cnt <= dw_cnt + DW_W'(1);
      end
    end else begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end

  assign scan_idx   = scan_cnt;
  assign scan_out   = mode_q ? ~(4'b0001 << scan_cnt[1:0]) : scan_cnt;
  assign kbd_active = mode_q | ~scan_cnt[3];
endmodule

module scan_timebase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       decoded,
  input logic       mode_q,
  input logic [3:0] scan_out,
  input logic [3:0] scan_idx,
  input logic       kbd_active,
  input logic       tick,
  input logic       digit_switch
);
  // R7
  ds_in_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digit_switch |-> tick);

  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!digit_switch && decoded == mode_q) |=> $stable(scan_idx));

  // R6
  one_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> ($countones(~scan_out) == 1 && scan_idx < 4'd4));

  // R5
  binary_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> scan_out == scan_idx);

  // R8
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decoded != mode_q) |=> (scan_idx == 4'd0 && !tick));

  // R9
  kbd_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && scan_idx >= 4'd8) |-> !kbd_active);
endmodule

bind scan_timebase scan_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .decoded(decoded), .mode_q(mode_q),
  .scan_out(scan_out), .scan_idx(scan_idx), .kbd_active(kbd_active),
  .tick(tick), .digit_switch(digit_switch)
);

// File: tb/scan_timebase_bench.sv
`timescale 1ns/1ps
module scan_timebase_bench;
  localparam int D = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] div_n = 5'd3;
  logic       decoded = 1'b0;
  logic [3:0] scan_out, scan_idx;
  logic       kbd_active, tick, digit_switch;

  always #2 clk = ~clk;

  scan_timebase #(.DIV_W(5), .DWELL_TICKS(D)) u_scan_timebase (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .decoded(decoded),
    .scan_out(scan_out), .scan_idx(scan_idx), .kbd_active(kbd_active),
    .tick(tick), .digit_switch(digit_switch)
  );

  typedef struct packed {
    logic [3:0] idx;
    logic [3:0] out;
    logic       kbd;
    int         period;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic hold = 1'b1;
  logic resync = 1'b0;
  logic cur_mode = 1'b0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: samples on the falling edge
  initial begin
    logic [3:0] prev_idx = '0;
    int cyc = 0;
    int ticks = 0;
    logic ds_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (hold && !resync) begin
        ds_prev = 1'b0;
      end else if (resync) begin
        check(scan_idx == 4'd0, "R8 index cleared by mode change", scan_idx, 0);
        check(scan_out == (cur_mode ? 4'b1110 : 4'b0000), "R8 scan lines at first position",
              scan_out, cur_mode ? 14 : 0);
        prev_idx = scan_idx;
        cyc = 0;
        ticks = 0;
        ds_prev = digit_switch;
        hold = 1'b0;
        resync = 1'b0;
      end else begin
        cyc++;
        if (scan_idx != prev_idx) begin
          exp_t e;
          check(ds_prev, "R7 digit_switch before advance", ds_prev, 1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected advance", scan_idx, prev_idx);
          end else begin
            e = exp_q.pop_front();
            check(scan_idx == e.idx, "R5/R6 next index", scan_idx, e.idx);
            check(scan_out == e.out, "R5/R6 scan lines", scan_out, e.out);
            check(kbd_active == e.kbd, "R9 keyboard row flag", kbd_active, e.kbd);
            check(cyc == e.period, "R4 clocks per position", cyc, e.period);
            check(ticks == D, "R2 ticks per position", ticks, D);
          end
          prev_idx = scan_idx;
          cyc = 0;
          ticks = 0;
        end else if (ds_prev) begin
          check(1'b0, "R7 digit_switch without advance", 1, 0);
        end
        if (tick) ticks++;
        ds_prev = digit_switch;
      end
    end
  end

  // driver: restart the scan in a mode, push the expected steps, wait for them
  task automatic run(input logic mode, input logic [4:0] n, input int steps);
    int eff;
    logic [3:0] idx;
    exp_t e;
    eff = (n < 2) ? 2 : int'(n);
    @(posedge clk); #1;
    hold = 1'b1;
    div_n = n;
    decoded = ~mode;
    @(posedge clk); #1;
    decoded = mode;
    cur_mode = mode;
    @(posedge clk); #1;
    idx = 4'd0;
    for (int i = 0; i < steps; i++) begin
      idx = mode ? {2'b00, idx[1:0] + 2'd1} : idx + 4'd1;
      e.idx = idx;
      e.out = mode ? ~(4'b0001 << idx[1:0]) : idx;
      e.kbd = mode | ~idx[3];
      e.period = eff * D;
      exp_q.push_back(e);
    end
    resync = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(scan_idx == 4'd0, "R1 reset index", scan_idx, 0);
    check(scan_out == 4'd0, "R1 reset scan lines", scan_out, 0);
    check(!tick && !digit_switch, "R1 reset pulses", {tick, digit_switch}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scan_idx == 4'd0 && !tick && !digit_switch, "R1 first cycle after reset",
          scan_idx, 0);
    // R2 R4 R5 R9: full binary wrap with ratio 3
    run(1'b0, 5'd3, 17);
    // R6: one-cold, ratio 5
    run(1'b1, 5'd5, 6);
    // R3: ratio 1 acts as 2
    run(1'b0, 5'd1, 5);
    // R2: widest ratio
    run(1'b0, 5'd31, 3);
    // R3 R6 R8: ratio 0 in one-cold mode after a binary run
    run(1'b1, 5'd0, 5);
    done = 1'b1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected finish", wd);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule